// File: doc/BRIEF.md
# Shared Write Queue and Read Prefetch Ring

This block sits between a host data port and a video memory controller. A four-slot, 16-bit ring holds the words the host writes until the memory side takes them. The same ring also holds the word fetched for the host when the port is switched to read mode. A mode command sets three things: read or write direction, whether the current target accepts writes, and which data bits the current target really stores. Command decoding, addressing and the memory arrays are outside the block.

Host writes are stored at the ring head and retired from the tail in order. A retired word becomes a memory write request only if the mode in force when the word was accepted allowed writes. Otherwise the slot is just released. In read mode, a fetch is started only once the ring is empty. The returned word is merged into the tail slot, which is the oldest position. Only the bits set in the mode's valid mask are replaced. The host then reads the word from the data port and takes it. Taking it starts the next fetch, which lands in the same slot.

Top module: `ring_fifo_ctrl`

## Requirements
- R1: After reset, ring_count is 0, ring_empty is 1, ring_full is 0, wr_ready is 1, rd_valid is 0 and mem_req is 0.
- R2: Committed writes reach memory one request per word, in acceptance order, with mem_we=1. mem_req, mem_we and mem_wdata stay stable until mem_ack.
- R3: ring_count equals accepted writes minus retired slots and never exceeds 4. ring_full is 1 exactly at 4. wr_ready is 0 while full, and a write offered then is not stored.
- R4: A read request (mem_req=1, mem_we=0) is only ever raised while ring_empty is 1. A read-mode command given with writes pending waits until they are all retired.
- R5: The fetched word is placed in slot (total accepted writes) mod 4, which is the oldest slot. When rd_valid is 1, rd_data shows that slot. For example, after writes 0x1111, 0x2222, 0x3333 and 0x4444, the fetch lands in the slot that held 0x1111.
- R6: A fetch replaces only the bits set in cmd_mask (1 = valid bit). All other bits of the slot keep their prior value.
- R7: A write accepted while cmd_writable=0 or cmd_read=1 is in force is stored and advances the ring, but raises no memory request.
- R8: When the host takes the word with rd_take, the next fetch is started in read mode and lands in the same slot. The pointers do not advance.
- R9: While a fetch is outstanding, wr_ready is 0. A host write, or a new mode command, clears rd_valid. A write accepted in the same cycle as cmd_set uses the previous mode.
- R10: A write accepted in the same cycle that mem_ack retires a write leaves ring_count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_set | input | 1 | Load a new mode |
| cmd_read | input | 1 | 1 = read mode, 0 = write mode |
| cmd_writable | input | 1 | 1 = target accepts writes |
| cmd_mask | input | 16 | Valid-bit mask for fetched data |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write word |
| wr_ready | output | 1 | Host write accepted this cycle if wr_valid |
| rd_valid | output | 1 | Fetched word available |
| rd_data | output | 16 | Word in the oldest slot |
| rd_take | input | 1 | Host consumes the fetched word |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_wdata | output | 16 | Write data to memory |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| ring_empty | output | 1 | No slot in use |
| ring_full | output | 1 | All four slots in use |
| ring_count | output | 3 | Slots in use |

## Verification
Two pairs of events can fall in the same cycle. The first is a host write being accepted in the same cycle that the memory acknowledges a retiring write. The bench creates it by queueing two words with the acknowledge held off, then offering a third word on the acknowledging edge; the count must stay at two. The second is a read-mode command arriving, or a host write landing, while the ring still holds work or a fetch could start. This is provoked by the doc-style four-write example and by writes made in read mode. It is judged by watching that no read request appears while the ring is non-empty, and that every fetched word matches the slot predicted from the write count and the mask. Random traffic with mixed acknowledge delays and mode changes repeats both pairs many times.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;
    localparam int unsigned WORD_W     = 16;
    localparam int unsigned RING_DEPTH = 4;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } mem_op_e;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] rd_idx,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [CW-1:0] wptr_d, wptr_q;
    logic [CW-1:0] rptr_d, rptr_q;

    always_comb begin
        wptr_d = wptr_q + {{PW{1'b0}}, push};
        rptr_d = rptr_q + {{PW{1'b0}}, pop};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            wptr_q <= wptr_d;
            rptr_q <= rptr_d;
        end
    end

    assign wr_idx = wptr_q[PW-1:0];
    assign rd_idx = rptr_q[PW-1:0];
    assign count  = wptr_q - rptr_q;
    assign empty  = (count == '0);
    assign full   = (count == CW'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/ring_slots.sv
module ring_slots #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned PW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_commit,
    input  logic              mg_en,
    input  logic [PW-1:0]     mg_idx,
    input  logic [DATA_W-1:0] mg_data,
    input  logic [DATA_W-1:0] mg_mask,
    input  logic [PW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_commit
);
    logic [DATA_W-1:0] data_d [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  commit_d, commit_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            data_d[i] = data_q[i];
        end
        commit_d = commit_q;
        if (wr_en) begin
            data_d[wr_idx]   = wr_data;
            commit_d[wr_idx] = wr_commit;
        end
        if (mg_en) begin
            data_d[mg_idx] = (data_q[mg_idx] & ~mg_mask) | (mg_data & mg_mask);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[g]   <= '0;
                commit_q[g] <= 1'b0;
            end else begin
                data_q[g]   <= data_d[g];
                commit_q[g] <= commit_d[g];
            end
        end
    end

    assign rd_data   = data_q[rd_idx];
    assign rd_commit = commit_q[rd_idx];

    p_merge_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mg_en && !wr_en |=> ((data_q[$past(mg_idx)] & ~$past(mg_mask)) ==
                             ($past(data_q[mg_idx]) & ~$past(mg_mask))));
endmodule

// File: rtl/ring_fifo_ctrl.sv
module ring_fifo_ctrl import ring_fifo_pkg::*; #(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned DEPTH  = RING_DEPTH,
    localparam int unsigned PW    = $clog2(DEPTH),
    localparam int unsigned CW    = PW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_set,
    input  logic              cmd_read,
    input  logic              cmd_writable,
    input  logic [DATA_W-1:0] cmd_mask,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_take,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ring_empty,
    output logic              ring_full,
    output logic [CW-1:0]     ring_count
);
    typedef struct packed {
        logic              busy;
        mem_op_e           op;
        logic              rd_mode;
        logic              writable;
        logic [DATA_W-1:0] mask;
        logic              rd_valid;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic              push, pop, mg_en, tail_commit;
    logic [PW-1:0]     head_idx, tail_idx;
    logic [DATA_W-1:0] tail_data;

    ring_ptr #(.DEPTH(DEPTH)) i_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .pop    (pop),
        .wr_idx (head_idx),
        .rd_idx (tail_idx),
        .count  (ring_count),
        .empty  (ring_empty),
        .full   (ring_full)
    );

    ring_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (push),
        .wr_idx    (head_idx),
        .wr_data   (wr_data),
        .wr_commit (s_q.writable && !s_q.rd_mode),
        .mg_en     (mg_en),
        .mg_idx    (tail_idx),
        .mg_data   (mem_rdata),
        .mg_mask   (s_q.mask),
        .rd_idx    (tail_idx),
        .rd_data   (tail_data),
        .rd_commit (tail_commit)
    );

    assign wr_ready = !ring_full && !(s_q.busy && s_q.op == OP_READ);
    assign push     = wr_valid && wr_ready;

    always_comb begin
        s_d   = s_q;
        pop   = 1'b0;
        mg_en = 1'b0;
        if (s_q.busy && mem_ack) begin
            s_d.busy = 1'b0;
            if (s_q.op == OP_WRITE) begin
                pop = 1'b1;
            end else begin
                mg_en      = 1'b1;
                s_d.rd_valid = s_q.rd_mode;
            end
        end else if (!s_q.busy) begin
            if (!ring_empty) begin
                if (tail_commit) begin
                    s_d.busy = 1'b1;
                    s_d.op   = OP_WRITE;
                end else begin
                    pop = 1'b1;
                end
            end else if (s_q.rd_mode && !s_q.rd_valid && !push && !cmd_set) begin
                s_d.busy = 1'b1;
                s_d.op   = OP_READ;
            end
        end
        if (rd_take && s_q.rd_valid) begin
            s_d.rd_valid = 1'b0;
        end
        if (push) begin
            s_d.rd_valid = 1'b0;
        end
        if (cmd_set) begin
            s_d.rd_mode  = cmd_read;
            s_d.writable = cmd_writable;
            s_d.mask     = cmd_mask;
            s_d.rd_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.busy     <= 1'b0;
            s_q.op       <= OP_WRITE;
            s_q.rd_mode  <= 1'b0;
            s_q.writable <= 1'b1;
            s_q.mask     <= '1;
            s_q.rd_valid <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req   = s_q.busy;
    assign mem_we    = (s_q.op == OP_WRITE);
    assign mem_wdata = tail_data;
    assign rd_data   = tail_data;
    assign rd_valid  = s_q.rd_valid;

    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we));
    p_wdata_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !mem_ack |=> $stable(mem_wdata));
    p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full |-> !wr_ready);
    p_read_when_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> ring_empty);
    p_fill_sets_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack && s_q.rd_mode && !cmd_set |=> rd_valid);
    p_fetch_blocks_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> !wr_ready);
    p_write_clears_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready |=> !rd_valid);
endmodule

// File: tb/test_ring_fifo_ctrl.sv
`timescale 1ns/1ps
module test_ring_fifo_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_set = 0, cmd_read = 0, cmd_writable = 1;
    logic [15:0] cmd_mask = 16'hFFFF;
    logic        wr_valid = 0;
    logic [15:0] wr_data = '0;
    logic        wr_ready, rd_valid, rd_take = 0;
    logic [15:0] rd_data;
    logic        mem_req, mem_we, mem_ack = 0;
    logic [15:0] mem_wdata, mem_rdata = '0;
    logic        ring_empty, ring_full;
    logic [2:0]  ring_count;

    int checks = 0, failures = 0, cyc = 0, nw = 0, nwr = 0;
    logic [15:0] mslot [4];
    logic [15:0] expq [$];
    logic        m_rd = 0, m_wr = 1;
    logic [15:0] m_mask = 16'hFFFF;
    bit          ack_on = 0, force_en = 0, done = 0;
    int          ack_pct = 100;
    logic [15:0] force_val = '0;

    always #2 clk = ~clk;

    ring_fifo_ctrl i_ring_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_set(cmd_set), .cmd_read(cmd_read),
        .cmd_writable(cmd_writable), .cmd_mask(cmd_mask), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_take(rd_take), .mem_req(mem_req), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ring_empty(ring_empty), .ring_full(ring_full), .ring_count(ring_count)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, nw_, mask);
        return (old & ~mask) | (nw_ & mask);
    endfunction

    task automatic step();
        logic commit;
        logic [15:0] e;
        int idx;
        mem_ack   = mem_req && ack_on && (($urandom % 100) < ack_pct);
        mem_rdata = (force_en && !mem_we) ? force_val : 16'($urandom);
        check(!(mem_req && !mem_we && !ring_empty), "R4 read request with ring busy",
              {31'd0, ring_empty}, 32'd1);
        check(!(mem_req && !mem_we && wr_ready), "R9 write open during fetch",
              {31'd0, wr_ready}, 32'd0);
        check(ring_full == (ring_count == 3'd4) && !(ring_full && wr_ready),
              "R3 full flag", {29'd0, ring_count}, 32'd4);
        if (rd_valid)
            check(rd_data == mslot[nw % 4], "R5 fetched word in oldest slot",
                  {16'd0, rd_data}, {16'd0, mslot[nw % 4]});
        commit = m_wr && !m_rd;
        if (mem_ack && mem_req) begin
            if (mem_we) begin
                nwr++;
                if (expq.size() == 0) begin
                    check(1'b0, "R7 memory write not expected", {16'd0, mem_wdata}, 32'd0);
                end else begin
                    e = expq.pop_front();
                    check(mem_wdata == e, "R2 drain order", {16'd0, mem_wdata}, {16'd0, e});
                end
            end else begin
                idx = nw % 4;
                mslot[idx] = merge(mslot[idx], mem_rdata, m_mask);
            end
        end
        if (wr_valid && wr_ready) begin
            mslot[nw % 4] = wr_data;
            nw++;
            if (commit) expq.push_back(wr_data);
        end
        if (cmd_set) begin
            m_rd = cmd_read; m_wr = cmd_writable; m_mask = cmd_mask;
        end
        @(posedge clk);
        @(negedge clk);
        wr_valid = 0; cmd_set = 0; rd_take = 0; mem_ack = 0;
        cyc++;
    endtask

    task automatic do_write(input logic [15:0] d);
        wr_valid = 1; wr_data = d; step();
    endtask

    task automatic set_mode(input logic rd, input logic wok, input logic [15:0] m);
        cmd_set = 1; cmd_read = rd; cmd_writable = wok; cmd_mask = m; step();
    endtask

    task automatic wait_fetch(input string tag, input logic [15:0] exp);
        for (int i = 0; i < 100 && !rd_valid; i++) step();
        check(rd_valid && rd_data == exp, tag, {15'd0, rd_valid, rd_data}, {16'd1, exp});
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            if (cyc > 150000) begin
                failures++;
                $display("FAIL watchdog expired actual=%0d expected=done", cyc);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : main
        int base;
        void'($urandom(32'd2718));
        for (int i = 0; i < 4; i++) mslot[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(ring_count == 0 && ring_empty && !ring_full && wr_ready && !rd_valid && !mem_req,
              "R1 reset state", {ring_count, ring_empty, ring_full, wr_ready, rd_valid, mem_req},
              {3'd0, 5'b10100});

        // R3 fill with memory stalled
        ack_on = 0;
        do_write(16'h1111); do_write(16'h2222); do_write(16'h3333); do_write(16'h4444);
        check(ring_count == 4 && ring_full && !wr_ready, "R3 ring full after four writes",
              {29'd0, ring_count}, 32'd4);
        do_write(16'h5555);
        check(ring_count == 4, "R3 write while full not stored", {29'd0, ring_count}, 32'd4);

        // R4 R5 R6 read setup with writes pending
        set_mode(1'b1, 1'b1, 16'h0EEE);
        ack_on = 1; ack_pct = 100; force_en = 1; force_val = 16'hFFFF;
        wait_fetch("R5 R6 fetch lands in slot of 0x1111", 16'h1FFF);
        check(ring_count == 0 && nwr == 4, "R4 all writes committed before fetch",
              nwr, 32'd4);

        // R8 refetch into same slot
        force_val = 16'h0000;
        set_mode(1'b1, 1'b1, 16'h07FF);
        wait_fetch("R6 bits outside mask kept", 16'h1800);
        force_val = 16'h0123;
        rd_take = 1; step();
        wait_fetch("R8 next fetch same slot", 16'h1923);

        // R7 non-writable target
        base = nwr;
        set_mode(1'b0, 1'b0, 16'hFFFF);
        do_write(16'h5555); do_write(16'h6666); do_write(16'h7777);
        repeat (10) step();
        check(ring_count == 0 && nwr == base, "R7 non-writable writes dropped",
              nwr, base);
        force_val = 16'hABCD;
        set_mode(1'b1, 1'b1, 16'h00FF);
        wait_fetch("R7 ring advanced by dropped writes", 16'h44CD);

        // R9 write in read mode clears rd_valid
        force_val = 16'h1234;
        do_write(16'h9999);
        check(!rd_valid, "R9 write clears rd_valid", {31'd0, rd_valid}, 32'd0);
        wait_fetch("R9 R5 refetch after read-mode write", 16'h5534);
        check(nwr == base, "R7 read-mode write not sent to memory", nwr, base);

        // R10 push and retire in the same cycle
        set_mode(1'b0, 1'b1, 16'hFFFF);
        ack_on = 0; force_en = 0;
        do_write(16'hA001); do_write(16'hA002);
        step();
        check(mem_req && mem_we, "R2 write request raised", {30'd0, mem_req, mem_we}, 32'd3);
        ack_on = 1; ack_pct = 100;
        do_write(16'hA003);
        check(ring_count == 2, "R10 count held on push plus retire",
              {29'd0, ring_count}, 32'd2);
        repeat (20) step();
        check(ring_count == 0, "R2 queue drained", {29'd0, ring_count}, 32'd0);

        // random traffic
        ack_pct = 50;
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 100) < 2) begin
                cmd_set = 1;
                cmd_read = (($urandom % 100) < 30);
                cmd_writable = $urandom % 2;
                case ($urandom % 4)
                    0: cmd_mask = 16'hFFFF;
                    1: cmd_mask = 16'h0EEE;
                    2: cmd_mask = 16'h07FF;
                    default: cmd_mask = 16'h00FF;
                endcase
            end
            if (($urandom % 100) < 40) begin
                wr_valid = 1; wr_data = 16'($urandom);
            end
            if (rd_valid && ($urandom % 2)) rd_take = 1;
            step();
        end

        set_mode(1'b0, 1'b1, 16'hFFFF);
        ack_pct = 100;
        repeat (40) step();
        check(ring_count == 0 && ring_empty, "R3 ring empty at end",
              {29'd0, ring_count}, 32'd0);
        check(expq.size() == 0, "R2 every committed write reached memory",
              expq.size(), 32'd0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule